// File: doc/BRIEF.md
# Decibel-Step Digital Gain Stage

This block scales a stream of signed 14-bit samples by a gain chosen in whole decibels, from 0 dB down to -19 dB in 1 dB steps. A 5-bit attenuation index selects a fixed-point coefficient from a constant table that is computed at elaboration. Each accepted sample is multiplied by its coefficient. The product is then rounded back to the sample width, saturated, and registered with a valid flag.

The stage sits between a sample source, such as a sum of filter outputs, and a converter. The index is sampled together with each valid sample, so the index can be changed at any time without creating a sample that was computed with two different gains. The pipeline has two stages: the first multiplies, and the second rounds and saturates.

Top module: `gain_db_step`

## Requirements
- R1: Setting k (0..19) uses the unsigned coefficient round(65536 * 10^(-k/20)). The coefficient has 1 integer bit and 16 fractional bits, so k=0 is exactly 65536 and k=19 is 7353.
- R2: Index values 20 to 31 produce the same result as index 19.
- R3: The output equals floor((sample * coef + 32768) / 65536), which is round half toward plus infinity, saturated to the range -8192..+8191.
- R4: With index 0 the output equals the input sample exactly, including +8191 and -8192.
- R5: `outValid` rises exactly two clock cycles after `inValid` is seen high. The result for that sample is presented in the same cycle.
- R6: The index is used only in the cycle where `inValid` is high. Back-to-back samples each use their own index, and index changes while `inValid` is low have no effect on any output.
- R7: `outSample` holds its last value in every cycle where `outValid` is low.
- R8: While `rst` is high, and after it is released, `outSample` is 0 and `outValid` is 0 until the first sample completes.
- R9: The magnitude of the output never exceeds the magnitude of the input sample it came from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample qualifier |
| inSample | input | 14 | Signed two's complement input sample |
| attenIdx | input | 5 | Attenuation in dB (0..19, larger values clamp to 19) |
| outValid | output | 1 | Output sample qualifier |
| outSample | output | 14 | Signed scaled, rounded and saturated output |

## Verification
The assertions check four things on every cycle:
- the two-cycle valid latency;
- that the output holds while it is not valid;
- exact pass-through at 0 dB;
- that the output magnitude never exceeds the input magnitude.

Only the bench scenarios can show the other behaviours. These are:
- the exact coefficient value for each of the 20 settings;
- clamping of the indices above 19;
- the direction of rounding on half-LSB ties for negative products;
- that a sample burst with a different index on every cycle keeps each gain with its own sample.

// File: rtl/gain_pkg.sv
package gain_pkg;
  localparam int DATA_W  = 14;
  localparam int FRAC_W  = 16;
  localparam int COEF_W  = FRAC_W + 1;
  localparam int IDX_W   = 5;
  localparam int STEPS   = 20;
  localparam int PROD_W  = DATA_W + COEF_W + 1;

  typedef struct packed {
    logic mulEn;   // capture a product in stage 1
    logic rndEn;   // capture a rounded result in stage 2
  } gainStrobes_t;

  // Linear amplitude ratio of k dB attenuation, in unsigned 1.FRAC_W format
  function automatic logic [COEF_W-1:0] coefOf(input int k);
    real ratio;
    ratio = 10.0 ** (-real'(k) / 20.0);
    return COEF_W'($rtoi(ratio * real'(1 << FRAC_W) + 0.5));
  endfunction
endpackage

// File: rtl/gain_ctrl.sv
module gain_ctrl
  import gain_pkg::*;
#(
  parameter int IW    = IDX_W,
  parameter int NSTEP = STEPS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [IW-1:0] attenIdx,
  output logic [IW-1:0] tableIdx,
  output gainStrobes_t  strobes,
  output logic          validOut
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NSTEP - 1);

  logic stage1Valid;
  logic stage2Valid;

  // Clamp out-of-range attenuation onto the deepest table entry
  always_comb begin
    tableIdx = (attenIdx > LAST_IDX) ? LAST_IDX : attenIdx;
  end

  always_comb begin
    strobes.mulEn = inValid;
    strobes.rndEn = stage1Valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  assign validOut = stage2Valid;
endmodule

// File: rtl/gain_coef_rom.sv
module gain_coef_rom
  import gain_pkg::*;
#(
  parameter int IW    = IDX_W,
  parameter int CW    = COEF_W,
  parameter int NSTEP = STEPS
) (
  input  logic [IW-1:0] tableIdx,
  output logic [CW-1:0] coef
);
  logic [CW-1:0] entries [NSTEP];

  for (genvar k = 0; k < NSTEP; k++) begin : g_entry
    localparam logic [CW-1:0] VAL = CW'(coefOf(k));
    assign entries[k] = VAL;
  end

  always_comb begin
    coef = entries[NSTEP-1];
    for (int k = 0; k < NSTEP; k++) begin
      if (tableIdx == IW'(k)) coef = entries[k];
    end
  end
endmodule

// File: rtl/gain_datapath.sv
module gain_datapath
  import gain_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = COEF_W,
  parameter int FW = FRAC_W,
  parameter int PW = PROD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  gainStrobes_t         strobes,
  input  logic signed [DW-1:0] inSample,
  input  logic        [CW-1:0] coef,
  output logic signed [DW-1:0] outSample
);
  localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (FW - 1);
  localparam logic signed [PW-1:0] POS_MAX  = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] NEG_MIN  = -PW'(1 << (DW - 1));

  logic signed [PW-1:0] sampleExt;
  logic signed [PW-1:0] coefExt;
  logic signed [PW-1:0] prodNext;
  logic signed [PW-1:0] prodQ;
  logic signed [PW-1:0] rounded;
  logic signed [DW-1:0] satNext;

  always_comb begin
    sampleExt = PW'(inSample);
    coefExt   = PW'($signed({1'b0, coef}));
    prodNext  = sampleExt * coefExt;
  end

  always_ff @(posedge clk) begin
    if (rst)                prodQ <= '0;
    else if (strobes.mulEn) prodQ <= prodNext;
  end

  always_comb begin
    rounded = (prodQ + HALF_LSB) >>> FW;
    if (rounded > POS_MAX)      satNext = POS_MAX[DW-1:0];
    else if (rounded < NEG_MIN) satNext = NEG_MIN[DW-1:0];
    else                        satNext = rounded[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                outSample <= '0;
    else if (strobes.rndEn) outSample <= satNext;
  end
endmodule

// File: rtl/gain_db_step.sv
module gain_db_step
  import gain_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic [IDX_W-1:0]         attenIdx,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample
);
  logic [IDX_W-1:0]  tableIdx;
  logic [COEF_W-1:0] coef;
  gainStrobes_t      strobes;

  gain_ctrl #(.IW(IDX_W), .NSTEP(STEPS)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .attenIdx(attenIdx),
    .tableIdx(tableIdx), .strobes(strobes), .validOut(outValid)
  );

  gain_coef_rom #(.IW(IDX_W), .CW(COEF_W), .NSTEP(STEPS)) rom_i (
    .tableIdx(tableIdx), .coef(coef)
  );

  gain_datapath #(.DW(DATA_W), .CW(COEF_W), .FW(FRAC_W), .PW(PROD_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .inSample(inSample),
    .coef(coef), .outSample(outSample)
  );
endmodule

// File: rtl/gain_db_step_chk.sv
module gain_db_step_chk
  import gain_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inSample,
  input logic [IDX_W-1:0]         attenIdx,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outSample
);
  function automatic int magOf(input logic signed [DATA_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) inValid |=> ##1 outValid); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) outValid |-> $past(inValid, 2)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !outValid |-> $stable(outSample)); // R7
  AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (rst) ($past(inValid, 2) && $past(attenIdx, 2) == '0) |-> outSample == $past(inSample, 2)); // R4
  AST_NO_GROWTH: assert property (@(posedge clk) disable iff (rst) $past(inValid, 2) |-> magOf(outSample) <= magOf($past(inSample, 2))); // R9
endmodule

bind gain_db_step gain_db_step_chk chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
  .attenIdx(attenIdx), .outValid(outValid), .outSample(outSample)
);

// File: tb/gain_db_step_tb.sv
module gain_db_step_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic signed [13:0] inSample = '0;
  logic [4:0]        attenIdx = '0;
  logic              outValid;
  logic signed [13:0] outSample;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Each entry is what the outputs must show two falling edges later
  typedef struct { bit v; int val; string tag; } expect_t;
  expect_t pipe[$];
  int heldVal = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gain_db_step dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .attenIdx(attenIdx), .outValid(outValid), .outSample(outSample)
  );

  function automatic longint refCoef(input int idx);
    int k;
    k = (idx > 19) ? 19 : idx;
    return longint'($rtoi(65536.0 * (10.0 ** (-real'(k) / 20.0)) + 0.5));
  endfunction

  function automatic int refGain(input int s, input int idx);
    longint p;
    longint r;
    p = longint'(s) * refCoef(idx);
    r = (p + 32768) >>> 16;
    if (r > 8191) r = 8191;
    if (r < -8192) r = -8192;
    return int'(r);
  endfunction

  task automatic checkVal(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: compare outputs, then drive the next inputs (all at negedge)
  task automatic step(input bit v, input int s, input int idx, input string tag);
    expect_t e;
    expect_t n;
    @(negedge clk);
    e = pipe.pop_front();
    if (e.v) heldVal = e.val;
    checkVal({e.tag, " valid"}, int'(outValid), int'(e.v));
    checkVal({e.tag, " sample"}, int'(outSample), heldVal);
    inValid  = v;
    inSample = 14'(s);
    attenIdx = 5'(idx);
    n.v = v;
    n.val = v ? refGain(s, idx) : 0;
    n.tag = tag;
    pipe.push_back(n);
  endtask

  task automatic idle(input int cycles, input int idx);
    for (int i = 0; i < cycles; i++) step(1'b0, 12345 % 8192, idx, "R7 idle hold");
  endtask

  initial begin
    fork
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
          miscompares++;
          vectors++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
          $finish;
        end
      end
    join_none

    // R8: reset state
    repeat (3) begin
      @(negedge clk);
      checkVal("R8 reset valid", int'(outValid), 0);
      checkVal("R8 reset sample", int'(outSample), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    begin
      expect_t z;
      z.v = 0; z.val = 0; z.tag = "R8 after reset";
      pipe.push_back(z);
      pipe.push_back(z);
    end

    // R4: unity gain at the extremes
    step(1, 8191, 0, "R4 unity max");
    step(1, -8192, 0, "R4 unity min");
    step(1, 0, 0, "R4 unity zero");
    step(1, -1, 0, "R4 unity minus one");
    idle(3, 0);

    // R1 / R3: every table entry on both rails and mid values
    for (int k = 0; k < 20; k++) begin
      step(1, 8191, k, "R1 coef pos rail");
      step(1, -8192, k, "R1 coef neg rail");
      step(1, 1000 - 37 * k, k, "R3 rounding mid");
      step(1, -3 - k, k, "R3 rounding small negative");
    end

    // R2: clamped indices match index 19
    for (int k = 20; k < 32; k++) begin
      step(1, 8191, k, "R2 clamp pos");
      step(1, -4097, k, "R2 clamp neg");
    end

    // R5 / R7: gaps with index toggling while idle
    step(1, 5000, 6, "R5 single sample");
    idle(4, 31);
    step(1, -5000, 2, "R5 single sample after gap");
    for (int i = 0; i < 4; i++) step(1'b0, -7000, i * 7, "R6 idle index change");

    // R6: back-to-back burst with a new index every cycle
    for (int i = 0; i < 24; i++)
      step(1, ((i * 1777) % 16384) - 8192, (i * 5) % 32, "R6 per-sample index");

    // R9 / R3: alternating-sign ramp at mid attenuation
    for (int i = 0; i < 16; i++)
      step(1, (i % 2) ? -(i * 511) : (i * 509), 9 + (i % 3), "R9 no growth");

    idle(4, 0);

    // R8: reset mid-stream returns outputs to zero
    step(1, 4000, 1, "R8 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkVal("R8 re-reset valid", int'(outValid), 0);
    checkVal("R8 re-reset sample", int'(outSample), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule